// File: doc/BRIEF.md
# Orderly Suspend Sequencer

This block lets a host pause a running network controller so that its configuration can be changed without a full reinitialization. The host writes a one to a suspend control bit. From that moment no new transmit or receive frame may start. The block waits until the transmit engine reports that its current frame and descriptor write-back are finished. Only after that does it wait for the receive engine to finish the same way. When both have drained, the read-back value of the suspend bit turns to one and the controller is suspended.

Writing zero to the bit resumes both engines at the ring positions they held when the suspend began. This is signalled by a one-cycle resume pulse. A stop command or a reset-register read cancels everything and puts the block into a halted state. Hardware reset does the same. From the halted state only a completed initialization restarts operation, and the ring positions are reloaded. The engines themselves are outside the block. Each one is seen only through a busy level and a drain-done pulse.

Top module: `suspend_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the block is halted. In that state `spnd_rdbk`=0, both start permits are 0, `rx_wb_hold`=0, `init_needed`=1, `cfg_open`=1 and `resume_pulse`=0.
- R2: `tx_start_ok` and `rx_start_ok` are 1 only in the running state. They drop in the cycle after a suspend request is accepted.
- R3: A write of 1 (`spnd_wr`=1, `spnd_wdata`=1) in the running state moves the block to the transmit-drain state in the next cycle. The block stays there while `tx_busy`=1 and `tx_done`=0. During transmit drain, `rx_wb_hold`=1 keeps the receive descriptor write-back waiting.
- R4: The transmit drain ends when `tx_done`=1 or `tx_busy`=0. The block then enters receive drain. The receive drain ends when `rx_done`=1 or `rx_busy`=0, and the block then enters suspend. Suspend is reached only from receive drain, and receive drain only from transmit drain.
- R5: `spnd_rdbk` is 1 exactly in the suspended state. `cfg_open` is 1 in the suspended and halted states and 0 otherwise.
- R6: A write of 0 while suspended returns the block to running in the next cycle. In that same cycle `resume_pulse`=1 for exactly one cycle and `init_needed` stays 0, so the ring positions are kept.
- R7: A write of 0 during either drain state returns the block directly to running. `spnd_rdbk` never shows 1 and no resume pulse is given.
- R8: `stop_set`=1 or `rstreg_rd`=1 in any state puts the block in the halted state in the next cycle, with `init_needed`=1. This has priority over any write in the same cycle.
- R9: In the halted state, suspend writes are ignored. `init_done`=1 moves the block to running in the next cycle.
- R10: A write of 1 during a drain or while suspended, a write of 0 while running, and `init_done` outside the halted state all leave every output as it would be without them.
- R11: When a write of 0 and the drain completion of the current engine fall in the same cycle, the write wins and the block goes to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| spnd_wr | input | 1 | Host write strobe for the suspend bit |
| spnd_wdata | input | 1 | Value written to the suspend bit |
| stop_set | input | 1 | Host sets the stop command |
| rstreg_rd | input | 1 | Host reads the software-reset register |
| init_done | input | 1 | Initialization sequence completed |
| tx_busy | input | 1 | Transmit engine has a frame or write-back in progress |
| tx_done | input | 1 | Transmit engine finished its drain (pulse) |
| rx_busy | input | 1 | Receive engine has a frame or write-back in progress |
| rx_done | input | 1 | Receive engine finished its drain (pulse) |
| tx_start_ok | output | 1 | A new transmit frame may start |
| rx_start_ok | output | 1 | A new receive frame may start |
| rx_wb_hold | output | 1 | Receive descriptor write-back must wait for transmit drain |
| spnd_rdbk | output | 1 | Read-back value of the suspend bit |
| init_needed | output | 1 | Halted; a full initialization is required |
| cfg_open | output | 1 | All control registers may be rewritten safely |
| resume_pulse | output | 1 | One cycle: continue at the saved ring positions |

## Verification
Two functions can fall in the same cycle: a drain state can receive the host's clearing write in the same cycle as the completion of the engine it is waiting on. A cancelling stop or reset-register read can also coincide with a suspend write. The bench provokes both by placing the block in each state and then applying every combination of the nine inputs for one cycle. It judges the next-cycle outputs against a next-state rule worked out from the requirements, in which cancel beats writes and a clearing write beats drain completion.

// File: rtl/pause_pkg.sv
package pause_pkg;

  typedef enum logic [2:0] {
    PS_HALT = 3'd0,
    PS_RUN  = 3'd1,
    PS_TXD  = 3'd2,
    PS_RXD  = 3'd3,
    PS_SUSP = 3'd4
  } pstate_e;

  localparam int ENG_N  = 2;
  localparam int ENG_TX = 0;
  localparam int ENG_RX = 1;

  // An engine counts as drained when it pulses done or is simply idle.
  function automatic logic drained(input logic busy, input logic done);
    return done | ~busy;
  endfunction

  // Next state: cancel first, then host writes, then drain progress.
  function automatic pstate_e pnext(input pstate_e s,
                                    input logic    cancel,
                                    input logic    wr_one,
                                    input logic    wr_zero,
                                    input logic    tx_fin,
                                    input logic    rx_fin,
                                    input logic    init_ok);
    pstate_e n;
    n = s;
    if (cancel) begin
      n = PS_HALT;
    end else begin
      unique case (s)
        PS_HALT: if (init_ok) n = PS_RUN;
        PS_RUN:  if (wr_one)  n = PS_TXD;
        PS_TXD: begin
          if (wr_zero)     n = PS_RUN;
          else if (tx_fin) n = PS_RXD;
        end
        PS_RXD: begin
          if (wr_zero)     n = PS_RUN;
          else if (rx_fin) n = PS_SUSP;
        end
        PS_SUSP: if (wr_zero) n = PS_RUN;
        default: n = PS_HALT;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/drain_watch.sv
module drain_watch (
  input  logic armed,
  input  logic busy,
  input  logic done,
  output logic quiet,
  output logic finish
);
  import pause_pkg::*;

  assign quiet  = drained(busy, done);
  assign finish = armed & quiet;

endmodule

// File: rtl/pause_fsm.sv
module pause_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_val,
  input  logic                cancel,
  input  logic                init_ok,
  input  logic                tx_fin,
  input  logic                rx_fin,
  output pause_pkg::pstate_e  state,
  output logic                resume_q,
  output logic                ev_request,
  output logic                ev_withdraw,
  output logic                ev_resume
);
  import pause_pkg::*;

  logic    wr_one, wr_zero, draining;
  pstate_e nxt;

  assign wr_one   = wr_en &  wr_val;
  assign wr_zero  = wr_en & ~wr_val;
  assign draining = (state == PS_TXD) || (state == PS_RXD);

  assign ev_request  = !cancel && (state == PS_RUN)  && wr_one;
  assign ev_withdraw = !cancel && draining           && wr_zero;
  assign ev_resume   = !cancel && (state == PS_SUSP) && wr_zero;

  assign nxt = pnext(state, cancel, wr_one, wr_zero, tx_fin, rx_fin, init_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PS_HALT;
      resume_q <= 1'b0;
    end else begin
      state    <= nxt;
      resume_q <= ev_resume;
    end
  end

  p_susp_from_rxd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SUSP && $past(state) != PS_SUSP) |-> $past(state) == PS_RXD);

  p_rxd_from_txd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RXD && $past(state) != PS_RXD) |-> $past(state) == PS_TXD);

  p_cancel_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> state == PS_HALT);

  p_resume_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resume |=> (state == PS_RUN && resume_q));

  p_withdraw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_withdraw |=> (state == PS_RUN && !resume_q));

  p_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_request |=> state == PS_TXD);

endmodule

// File: rtl/pause_outdec.sv
module pause_outdec (
  input  logic                clk,
  input  logic                rst_n,
  input  pause_pkg::pstate_e  state,
  input  logic                resume_q,
  output logic                tx_ok,
  output logic                rx_ok,
  output logic                wb_hold,
  output logic                rdbk,
  output logic                need_init,
  output logic                open,
  output logic                resume
);
  import pause_pkg::*;

  always_comb begin
    tx_ok     = 1'b0;
    rx_ok     = 1'b0;
    wb_hold   = 1'b0;
    rdbk      = 1'b0;
    need_init = 1'b0;
    open      = 1'b0;
    unique case (state)
      PS_RUN:  begin tx_ok = 1'b1; rx_ok = 1'b1; end
      PS_TXD:  wb_hold = 1'b1;
      PS_RXD:  ;
      PS_SUSP: begin rdbk = 1'b1; open = 1'b1; end
      default: begin need_init = 1'b1; open = 1'b1; end
    endcase
  end

  assign resume = resume_q;

  p_rdbk_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdbk |-> (!tx_ok && !rx_ok && !wb_hold));

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  p_pulse_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (tx_ok && rx_ok && !need_init));

  p_rdbk_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdbk) |-> $past(!tx_ok && !wb_hold));

endmodule

// File: rtl/suspend_sequencer.sv
module suspend_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic spnd_wr,
  input  logic spnd_wdata,
  input  logic stop_set,
  input  logic rstreg_rd,
  input  logic init_done,
  input  logic tx_busy,
  input  logic tx_done,
  input  logic rx_busy,
  input  logic rx_done,
  output logic tx_start_ok,
  output logic rx_start_ok,
  output logic rx_wb_hold,
  output logic spnd_rdbk,
  output logic init_needed,
  output logic cfg_open,
  output logic resume_pulse
);
  import pause_pkg::*;

  localparam int NE = ENG_N;

  pstate_e         state;
  logic            resume_q;
  logic            cancel;
  logic [NE-1:0]   eng_busy, eng_done, eng_arm, eng_quiet, eng_fin;
  logic            ev_request, ev_withdraw, ev_resume;

  assign cancel = stop_set | rstreg_rd;

  assign eng_busy[ENG_TX] = tx_busy;
  assign eng_busy[ENG_RX] = rx_busy;
  assign eng_done[ENG_TX] = tx_done;
  assign eng_done[ENG_RX] = rx_done;
  assign eng_arm[ENG_TX]  = (state == PS_TXD);
  assign eng_arm[ENG_RX]  = (state == PS_RXD);

  for (genvar g = 0; g < NE; g++) begin : g_eng
    drain_watch u_dw (
      .armed  (eng_arm[g]),
      .busy   (eng_busy[g]),
      .done   (eng_done[g]),
      .quiet  (eng_quiet[g]),
      .finish (eng_fin[g])
    );
  end

  pause_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (spnd_wr),
    .wr_val      (spnd_wdata),
    .cancel      (cancel),
    .init_ok     (init_done),
    .tx_fin      (eng_fin[ENG_TX]),
    .rx_fin      (eng_fin[ENG_RX]),
    .state       (state),
    .resume_q    (resume_q),
    .ev_request  (ev_request),
    .ev_withdraw (ev_withdraw),
    .ev_resume   (ev_resume)
  );

  pause_outdec u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .resume_q  (resume_q),
    .tx_ok     (tx_start_ok),
    .rx_ok     (rx_start_ok),
    .wb_hold   (rx_wb_hold),
    .rdbk      (spnd_rdbk),
    .need_init (init_needed),
    .open      (cfg_open),
    .resume    (resume_pulse)
  );

  // R11: a clearing write beats the drain completion in the same cycle
  p_clear_beats_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_withdraw && (eng_quiet[ENG_TX] || eng_quiet[ENG_RX])) |=> tx_start_ok);

  p_stay_in_txd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wb_hold && !cancel && !spnd_wr && !eng_quiet[ENG_TX]) |=> rx_wb_hold);

  p_request_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_request |=> (!tx_start_ok && !rx_start_ok));

endmodule

// File: tb/suspend_sequencer_tb.sv
module suspend_sequencer_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spnd_wr = 0, spnd_wdata = 0, stop_set = 0, rstreg_rd = 0, init_done = 0;
  logic tx_busy = 0, tx_done = 0, rx_busy = 0, rx_done = 0;
  logic tx_start_ok, rx_start_ok, rx_wb_hold, spnd_rdbk, init_needed, cfg_open, resume_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  suspend_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .spnd_wr(spnd_wr), .spnd_wdata(spnd_wdata),
    .stop_set(stop_set), .rstreg_rd(rstreg_rd), .init_done(init_done),
    .tx_busy(tx_busy), .tx_done(tx_done), .rx_busy(rx_busy), .rx_done(rx_done),
    .tx_start_ok(tx_start_ok), .rx_start_ok(rx_start_ok), .rx_wb_hold(rx_wb_hold),
    .spnd_rdbk(spnd_rdbk), .init_needed(init_needed), .cfg_open(cfg_open),
    .resume_pulse(resume_pulse)
  );

  // Bench state codes: 0 halted, 1 running, 2 tx drain, 3 rx drain, 4 suspended
  function automatic logic [6:0] expect_vec(int s, bit res);
    logic run = (s == 1);
    // order: tx_ok rx_ok hold rdbk init open resume
    return {run, run, s == 2, s == 4, s == 0, (s == 0) || (s == 4), res};
  endfunction

  function automatic logic [6:0] got_vec();
    return {tx_start_ok, rx_start_ok, rx_wb_hold, spnd_rdbk, init_needed, cfg_open, resume_pulse};
  endfunction

  task automatic check(input logic [6:0] got, input logic [6:0] exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // v bits: 8 wr, 7 wdata, 6 stop, 5 rstreg, 4 tx_busy, 3 tx_done, 2 rx_busy, 1 rx_done, 0 init
  task automatic step(input logic [8:0] v);
    @(negedge clk);
    {spnd_wr, spnd_wdata, stop_set, rstreg_rd, tx_busy, tx_done, rx_busy, rx_done, init_done} = v;
    @(posedge clk);
    #1;
  endtask

  task automatic goto_state(input int s);
    @(negedge clk);
    rst_n = 1'b0;
    {spnd_wr, spnd_wdata, stop_set, rstreg_rd, tx_busy, tx_done, rx_busy, rx_done, init_done} = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    if (s >= 1) step(9'b0_0_0_0_0_0_0_0_1);
    if (s >= 2) step(9'b1_1_0_0_1_0_0_0_0);
    if (s >= 3) step(9'b0_0_0_0_0_0_1_0_0);
    if (s >= 4) step(9'b0_0_0_0_0_0_0_0_0);
  endtask

  // Expected successor, worked out from R3..R11
  function automatic int succ(int s, logic [8:0] v, output bit res, output string tag);
    bit set1  = v[8] &&  v[7];
    bit clr   = v[8] && !v[7];
    bit cut   = v[6] || v[5];
    bit txq   = v[3] || !v[4];
    bit rxq   = v[1] || !v[2];
    res = 0;
    if (cut) begin tag = "R8"; return 0; end
    if (s == 0) begin tag = "R9"; return v[0] ? 1 : 0; end
    if (s == 4) begin
      if (clr) begin tag = "R6"; res = 1; return 1; end
      tag = "R10"; return 4;
    end
    if (s == 1) begin
      if (set1) begin tag = "R3"; return 2; end
      tag = "R10"; return 1;
    end
    // drain states
    if (clr) begin
      tag = ((s == 2 && txq) || (s == 3 && rxq)) ? "R11" : "R7";
      return 1;
    end
    if (s == 2) begin tag = txq ? "R4" : "R3"; return txq ? 3 : 2; end
    tag = rxq ? "R4" : "R10"; return rxq ? 4 : 3;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset values, during and just after reset
    repeat (2) @(posedge clk);
    #1;
    check(got_vec(), expect_vec(0, 0), "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(got_vec(), expect_vec(0, 0), "R1 after release");

    // Directed walk: suspend, resume, and readback held low until both drains finish
    goto_state(1);
    step(9'b1_1_0_0_1_0_1_0_0);
    check(got_vec(), expect_vec(2, 0), "R2 request blocks starts");
    step(9'b0_0_0_0_1_0_1_0_0);
    check(got_vec(), expect_vec(2, 0), "R3 tx still busy");
    step(9'b0_0_0_0_1_1_1_0_0);
    check(got_vec(), expect_vec(3, 0), "R4 tx done pulse");
    step(9'b0_0_0_0_0_0_1_0_0);
    check(got_vec(), expect_vec(3, 0), "R5 rdbk low in rx drain");
    step(9'b0_0_0_0_0_0_1_1_0);
    check(got_vec(), expect_vec(4, 0), "R5 rdbk high when suspended");
    step(9'b0_0_0_0_0_0_0_0_0);
    check(got_vec(), expect_vec(4, 0), "R5 stays suspended");
    step(9'b1_0_0_0_0_0_0_0_0);
    check(got_vec(), expect_vec(1, 1), "R6 resume pulse");
    step(9'b0_0_0_0_0_0_0_0_0);
    check(got_vec(), expect_vec(1, 0), "R6 pulse one cycle");

    // Exhaustive sweep: each state x every input combination
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < 512; c++) begin
        bit    res;
        string tag;
        int    ns;
        goto_state(s);
        ns = succ(s, c[8:0], res, tag);
        step(c[8:0]);
        check(got_vec(), expect_vec(ns, res), $sformatf("%s s=%0d in=%b", tag, s, c[8:0]));
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule